// File: doc/BRIEF.md
# Integer ALU with Condition Codes

This block is the integer execute unit of a small load/store RISC core. It combines two 32-bit operands under a 6-bit operation code. It returns the result together with the next values of four condition flags: negative, zero, overflow and carry. It also returns a strobe that says whether those flags are written. All of these outputs are combinational.

A small flag holder inside the block stores the condition codes between operations. Its carry bit is the carry-in for the add-with-carry operations, so a chain of operations behaves as it would in a core.

The operations are arithmetic (add, subtract, add-with-carry), bitwise (AND, OR, XOR and the three forms that invert the second operand) and shifts (left, logical right, arithmetic right). Each arithmetic and bitwise operation also has a flag-setting form, whose code is the base code plus 16. Any code outside the map is reported as illegal and has no effect on the flags.

Top module: `int_alu_cc`

## Requirements
- R1: After reset the flag holder `flags_o` reads 0. The flag vector layout is {N, Z, V, C} in bits 3 down to 0.
- R2: Codes 0x01, 0x02 and 0x03 give A AND B, A OR B and A XOR B. Codes 0x05, 0x06 and 0x07 give A AND NOT B, A OR NOT B and A XOR NOT B.
- R3: Code 0x00 gives A+B, code 0x04 gives A-B and code 0x08 gives A+B+C, where C is the stored carry flag. All results are taken modulo 2^32.
- R4: Flag-setting adds (0x10) set N to result bit 31 and Z when all 32 result bits are 0. They set V when both operand signs are equal and differ from the result sign, and C to the unsigned carry out of bit 31.
- R5: Flag-setting subtract (0x14) sets N and Z as in R4. It sets V when the operand signs differ and the result sign differs from A, and C (borrow) when A is below B as unsigned numbers.
- R6: Flag-setting bitwise codes (0x11, 0x12, 0x13, 0x15, 0x16, 0x17) set N and Z from the result and clear V and C.
- R7: Code 0x25 shifts left logically, 0x26 shifts right logically and 0x27 shifts right arithmetically, filling with the original bit 31. The amount is B[4:0], and an amount of 0 returns A unchanged.
- R8: Codes 0x00 to 0x08 and the three shift codes drive `flags_we_o` low and leave `flags_o` unchanged.
- R9: Any other code drives `illegal_o` high, drives the result to 0 and `flags_we_o` low, and leaves `flags_o` unchanged.
- R10: Codes 0x10 to 0x18 drive `flags_we_o` high, and `flags_o` takes `flags_next_o` at the next rising clock edge.
- R11: Code 0x18 returns A+B+C and sets all four flags from that full sum, with C as the true carry out of the three-input addition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag holder |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 6 | Operation code |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand, which also supplies the shift amount |
| result_o | output | 32 | Operation result |
| flags_next_o | output | 4 | Next flag values {N,Z,V,C} |
| flags_we_o | output | 1 | High when the operation writes the flags |
| illegal_o | output | 1 | High for a code outside the map |
| flags_o | output | 4 | Stored flags {N,Z,V,C} |

## Verification
The result, the illegal indication, the write strobe and the next flags are due in the same cycle that the operands and code are applied. The stored flags are due only after the following rising edge. The bench therefore applies each stimulus on a falling edge and samples the combinational outputs shortly afterwards. It then waits for the next rising edge and compares the flag holder against the flags that its own model committed. The carry used by add-with-carry comes from the model's tracked flags, so a permuted order of codes over a sweep of operand pairs exercises both carry-in values.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;
    localparam int OP_W   = 6;
    localparam int CC_BIT = 4;

    // low four bits of a base (non-shift) code
    localparam logic [3:0] B_ADD  = 4'h0;
    localparam logic [3:0] B_SUB  = 4'h4;
    localparam logic [3:0] B_ADDC = 4'h8;

    localparam logic [OP_W-1:0] OP_SHL = 6'h25;
    localparam logic [OP_W-1:0] OP_SHR = 6'h26;
    localparam logic [OP_W-1:0] OP_SAR = 6'h27;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_RIGHT = 2'd1,
        SH_ARITH = 2'd2
    } shift_kind_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             carry_o,
    output logic             ovf_o
);
    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   ext;

    always_comb begin
        b_eff   = sub_i ? ~b_i : b_i;
        ext     = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, (sub_i | cin_i)};
        sum_o   = ext[WIDTH-1:0];
        // subtraction reports borrow, the inverse of the carry out
        carry_o = sub_i ? ~ext[WIDTH] : ext[WIDTH];
        ovf_o   = (a_i[WIDTH-1] == b_eff[WIDTH-1]) && (ext[WIDTH-1] != a_i[WIDTH-1]);
    end
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [2:0]       sel_i,
    output logic [WIDTH-1:0] res_o
);
    logic [WIDTH-1:0] b_eff;

    always_comb begin
        b_eff = sel_i[2] ? ~b_i : b_i;
        unique case (sel_i[1:0])
            2'd1:    res_o = a_i & b_eff;
            2'd2:    res_o = a_i | b_eff;
            2'd3:    res_o = a_i ^ b_eff;
            default: res_o = '0;
        endcase
    end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
    import alu_cc_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int SHW  = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [SHW-1:0]   amt_i,
    input  shift_kind_e      kind_i,
    output logic [WIDTH-1:0] res_o
);
    always_comb begin
        unique case (kind_i)
            SH_LEFT:  res_o = a_i << amt_i;
            SH_RIGHT: res_o = a_i >> amt_i;
            SH_ARITH: res_o = WIDTH'($signed(a_i) >>> amt_i);
            default:  res_o = a_i;
        endcase
    end
endmodule

// File: rtl/int_alu_cc.sv
module int_alu_cc
    import alu_cc_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int SHW  = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OP_W-1:0]  op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] result_o,
    output logic [3:0]       flags_next_o,
    output logic             flags_we_o,
    output logic             illegal_o,
    output logic [3:0]       flags_o
);
    typedef struct packed {
        logic [WIDTH-1:0] result;
        ccr_t             cc;
        logic             we;
        logic             ill;
    } step_t;

    step_t st_d;
    ccr_t  ccr_q, ccr_d;

    logic [3:0]       base;
    logic             is_base, is_shift, is_logic, is_sub, is_addc;
    logic [WIDTH-1:0] sum, bits, shifted;
    logic             carry, ovf;
    shift_kind_e      sh_kind;

    always_comb begin
        base     = op_i[3:0];
        is_base  = (op_i[5] == 1'b0) && (op_i[3:0] <= B_ADDC) && (op_i[3:0] == 4'h8 ? 1'b1 : !op_i[3]);
        is_shift = (op_i == OP_SHL) || (op_i == OP_SHR) || (op_i == OP_SAR);
        is_sub   = (base == B_SUB);
        is_addc  = (base == B_ADDC);
        is_logic = is_base && (base != B_ADD) && !is_sub && !is_addc;
        unique case (op_i)
            OP_SHL:  sh_kind = SH_LEFT;
            OP_SHR:  sh_kind = SH_RIGHT;
            default: sh_kind = SH_ARITH;
        endcase
    end

    alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a_i    (a_i),
        .b_i    (b_i),
        .sub_i  (is_sub),
        .cin_i  (is_addc & ccr_q.c),
        .sum_o  (sum),
        .carry_o(carry),
        .ovf_o  (ovf)
    );

    alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
        .a_i  (a_i),
        .b_i  (b_i),
        .sel_i(base[2:0]),
        .res_o(bits)
    );

    alu_shifter #(.WIDTH(WIDTH)) u_shifter (
        .a_i   (a_i),
        .amt_i (b_i[SHW-1:0]),
        .kind_i(sh_kind),
        .res_o (shifted)
    );

    always_comb begin
        st_d        = '0;
        st_d.cc     = ccr_q;
        if (is_shift) begin
            st_d.result = shifted;
        end else if (is_base) begin
            st_d.result = is_logic ? bits : sum;
            st_d.we     = op_i[CC_BIT];
            if (op_i[CC_BIT]) begin
                st_d.cc.n = st_d.result[WIDTH-1];
                st_d.cc.z = (st_d.result == '0);
                st_d.cc.v = is_logic ? 1'b0 : ovf;
                st_d.cc.c = is_logic ? 1'b0 : carry;
            end
        end else begin
            st_d.ill = 1'b1;
        end
        ccr_d = st_d.we ? st_d.cc : ccr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ccr_q <= '0;
        else        ccr_q <= ccr_d;
    end

    assign result_o     = st_d.result;
    assign flags_next_o = st_d.cc;
    assign flags_we_o   = st_d.we;
    assign illegal_o    = st_d.ill;
    assign flags_o      = ccr_q;

    // R4: written N and Z agree with the result produced by the datapath
    p_nz_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flags_we_o |-> (flags_next_o[3] == result_o[WIDTH-1]) && (flags_next_o[2] == (result_o == '0)));

    // R6: bitwise flag-setting codes never report overflow or carry
    p_logic_vc_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_we_o && op_i[2:0] != 3'd0 && op_i[2:0] != 3'd4 && !op_i[3]) |-> (flags_next_o[1:0] == 2'b00));

    // R8: no write strobe means the holder keeps its value
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !flags_we_o |=> $stable(flags_o));

    // R9: illegal code neither writes flags nor yields data
    p_illegal_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!flags_we_o && result_o == '0));

    // R10: strobed flags land in the holder one edge later
    p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flags_we_o |=> (flags_o == $past(flags_next_o)));
endmodule

// File: tb/int_alu_cc_tb.sv
module int_alu_cc_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  op_i = '0;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic [31:0] result_o;
    logic [3:0]  flags_next_o;
    logic        flags_we_o;
    logic        illegal_o;
    logic [3:0]  flags_o;

    int total = 0;
    int bad   = 0;
    logic [3:0] mflags = 4'h0;

    always #5 clk = ~clk;

    int_alu_cc u_dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i),
        .result_o(result_o), .flags_next_o(flags_next_o), .flags_we_o(flags_we_o),
        .illegal_o(illegal_o), .flags_o(flags_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s op=%02h a=%08h b=%08h actual=%08h expected=%08h",
                     tag, op_i, a_i, b_i, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // arithmetic reference model over {N,Z,V,C}
    task automatic model(input logic [5:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic cin, output logic [31:0] r, output logic [3:0] f,
                         output logic we, output logic ill, output string rtag, output string ftag);
        logic [32:0] wide;
        logic        lg;
        logic [3:0]  bs;
        r = 32'h0; f = mflags; we = 1'b0; ill = 1'b0; lg = 1'b0; wide = '0;
        bs = op[3:0];
        rtag = "R9"; ftag = "R9";
        if (op == 6'h25) begin r = a << b[4:0]; rtag = "R7"; ftag = "R8"; end
        else if (op == 6'h26) begin r = a >> b[4:0]; rtag = "R7"; ftag = "R8"; end
        else if (op == 6'h27) begin
            r = a >> b[4:0];
            for (int i = 0; i < 32; i++) if (a[31] && i >= 32 - int'(b[4:0])) r[i] = 1'b1;
            rtag = "R7"; ftag = "R8";
        end else if (!op[5] && (op[4:0] <= 5'h08 || (op[4] && op[3:0] <= 4'h8))) begin
            we = op[4];
            case (bs)
                4'h0: begin wide = {1'b0, a} + {1'b0, b}; rtag = "R3"; end
                4'h4: begin wide = {1'b0, a} - {1'b0, b}; rtag = "R3"; end
                4'h8: begin wide = {1'b0, a} + {1'b0, b} + {32'h0, cin}; rtag = "R3"; end
                4'h1: begin wide[31:0] = a & b;  lg = 1'b1; rtag = "R2"; end
                4'h2: begin wide[31:0] = a | b;  lg = 1'b1; rtag = "R2"; end
                4'h3: begin wide[31:0] = a ^ b;  lg = 1'b1; rtag = "R2"; end
                4'h5: begin wide[31:0] = a & ~b; lg = 1'b1; rtag = "R2"; end
                4'h6: begin wide[31:0] = a | ~b; lg = 1'b1; rtag = "R2"; end
                default: begin wide[31:0] = a ^ ~b; lg = 1'b1; rtag = "R2"; end
            endcase
            r = wide[31:0];
            if (!we) ftag = "R8";
            else begin
                f[3] = r[31];
                f[2] = (r == 32'h0);
                if (lg) begin f[1:0] = 2'b00; ftag = "R6"; end
                else if (bs == 4'h4) begin
                    f[1] = (a[31] != b[31]) && (r[31] != a[31]);
                    f[0] = (a < b);
                    ftag = "R5";
                end else begin
                    f[1] = (a[31] == b[31]) && (r[31] != a[31]);
                    f[0] = wide[32];
                    ftag = (bs == 4'h8) ? "R11" : "R4";
                end
            end
        end else ill = 1'b1;
    endtask

    task automatic apply(input logic [5:0] op, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] er;
        logic [3:0]  ef;
        logic        ewe, eill;
        string       rt, ft;
        @(negedge clk);
        op_i = op; a_i = a; b_i = b;
        #1;
        model(op, a, b, mflags[0], er, ef, ewe, eill, rt, ft);
        check(rt, result_o, er);
        check(ft, {31'h0, flags_we_o}, {31'h0, ewe});
        check(eill ? "R9" : rt, {31'h0, illegal_o}, {31'h0, eill});
        if (ewe) check(ft, {28'h0, flags_next_o}, {28'h0, ef});
        if (ewe) mflags = ef;
        @(posedge clk);
        #1;
        check(ewe ? "R10" : ft, {28'h0, flags_o}, {28'h0, mflags});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] av [8];
        logic [31:0] bv [8];
        av = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, 32'h1234_5678, 32'h0000_001F, 32'hA5A5_A5A0};
        bv = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, 32'd31, 32'd32, 32'h5A5A_5A5F};
        repeat (3) @(posedge clk);
        #1;
        check("R1", {28'h0, flags_o}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // directed corner cases
        apply(6'h27, 32'h8000_0000, 32'd31);   // R7 sign fill -> all ones
        apply(6'h27, 32'h8000_0010, 32'd32);   // R7 amount 0 -> unchanged
        apply(6'h14, 32'h0, 32'h1);            // R5 borrow sets C
        apply(6'h08, 32'd5, 32'd6);            // R3 add-with-carry sees C
        apply(6'h18, 32'hFFFF_FFFF, 32'h0);    // R11 carry-in wraps to zero
        apply(6'h11, 32'hF0F0_0000, 32'h0F0F_FFFF); // R6 zero result, V/C cleared
        apply(6'h3F, 32'h1, 32'h1);            // R9 undefined code
        apply(6'h10, 32'h7FFF_FFFF, 32'h1);    // R4 signed overflow

        // sweep: every code over an operand grid, permuted code order
        foreach (av[i]) begin
            foreach (bv[j]) begin
                for (int k = 0; k < 64; k++) begin
                    apply(6'((k * 37 + i * 8 + j) & 63), av[i], bv[j]);
                end
            end
        end

        // R1: reset clears a non-zero holder
        apply(6'h13, 32'h8000_0000, 32'h0);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        mflags = 4'h0;
        check("R1", {28'h0, flags_o}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        finish_run();
    end
endmodule